// File: doc/BRIEF.md
# Video ROI and Subsampling Filter

This block sits on a parallel camera pixel stream qualified by frame-valid, line-valid and data-valid. It decides which pixels travel downstream. Each pixel it keeps leaves with a valid strobe, a start-of-frame marker on the first kept pixel of a frame, and an end-of-line marker on the last kept pixel of each line. It crops the stream in one of three modes. Area mode keeps a rectangle. Line mode keeps a horizontal window and groups lines into pseudo-frames of a programmed height. Stream mode keeps every qualified pixel. Horizontal and vertical power-of-two decimation apply independently in every mode.

The setup is presented on plain input ports. The block latches it on the rising edge of frame-valid, and holds it for the whole frame. The block keeps the most recent kept pixel in a one-deep holding stage. The held pixel is released when the next kept pixel arrives, or when the line closes. The line closes when line-valid or frame-valid drops. This lets the end-of-line marker work in stream mode as well, where the line length is unknown in advance.

Top module: `vid_roi_filter`

## Requirements
- R1: With mode code 0 (area), a pixel with in-line index x on line y of a frame is kept only when x_off ≤ x < x_off+width and y_off ≤ y < y_off+height. Indices count from 0 and advance only on data-valid beats.
- R2: With mode code 1 (line), only x_off and width crop pixels. No vertical offset or vertical limit applies.
- R3: In line mode, once `height` kept lines have ended, the line index restarts at 0, and the next kept pixel carries sof_o. A height of 0 disables this grouping.
- R4: With mode code 2 or 3 (stream), every pixel with frame-valid, line-valid and data-valid high is a candidate. x_off, y_off, width and height are ignored.
- R5: Decimation code n (0..3) on x_dec_i and y_dec_i selects a factor of 2^n. A pixel is kept only if (x − x_off) mod 2^x_dec is 0. A line is kept only if (y − y_off) mod 2^y_dec is 0. The offsets count as 0 in stream mode, and y_off counts as 0 in line mode.
- R6: Cycles with data-valid low neither advance the pixel index nor produce output.
- R7: The first kept pixel after a rising edge of frame-valid carries sof_o. No other pixel carries it, except as set out in R3.
- R8: The last kept pixel of each line carries eol_o. It appears one cycle after the line closes. Kept pixels leave in arrival order, each one cycle after the next kept pixel of its line arrives.
- R9: Mode, offsets, sizes and decimation codes are captured at the rising edge of frame-valid. Changing them mid-frame does not affect the current frame.
- R10: While reset is asserted, valid_o, sof_o and eol_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fval_i | input | 1 | Frame valid |
| lval_i | input | 1 | Line valid |
| dval_i | input | 1 | Data valid |
| pix_i | input | PIX_W | Pixel data |
| mode_i | input | 2 | 0 area, 1 line, 2/3 stream |
| x_off_i | input | CNT_W | Horizontal offset |
| y_off_i | input | CNT_W | Vertical offset (area mode) |
| width_i | input | CNT_W | Window width in source pixels |
| height_i | input | CNT_W | Window height (area) or pseudo-frame size in kept lines (line) |
| x_dec_i | input | 2 | Horizontal decimation code |
| y_dec_i | input | 2 | Vertical decimation code |
| pix_o | output | PIX_W | Kept pixel |
| valid_o | output | 1 | Kept pixel strobe |
| sof_o | output | 1 | First kept pixel of a frame or pseudo-frame |
| eol_o | output | 1 | Last kept pixel of a line |

## Verification
Each scenario drives frames whose pixel values encode line and position. The sequence that comes out, with its markers, is compared against a model of the cropping rules.

- An undecimated rectangle with nonzero offsets checks both window edges.
- Factors of 4 across and 2 down, combined with data-valid gaps, separate decimation phase from offset alignment and from stall handling.
- Line mode with height 2 shows pseudo-frame starts. Line mode with height 0 and vertical decimation shows that grouping is off.
- Stream mode with varying line lengths and nonzero offsets shows that the crop settings are ignored, and that the end-of-line marker follows the actual line end.
- A mid-frame setup change shows that the frame is unaffected until the next one begins.

// File: rtl/vid_roi_pkg.sv
package vid_roi_pkg;
  typedef enum logic [1:0] {
    MODE_AREA   = 2'd0,
    MODE_LINE   = 2'd1,
    MODE_STREAM = 2'd2,
    MODE_STRM2  = 2'd3
  } roi_mode_e;
endpackage

// File: rtl/vid_roi_cfg.sv
module vid_roi_cfg #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_start_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] x_off_i,
  input  logic [CNT_W-1:0] y_off_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] height_i,
  input  logic [1:0]       x_dec_i,
  input  logic [1:0]       y_dec_i,
  output logic [1:0]       mode_o,
  output logic [CNT_W-1:0] x_off_o,
  output logic [CNT_W-1:0] y_off_o,
  output logic [CNT_W-1:0] width_o,
  output logic [CNT_W-1:0] height_o,
  output logic [1:0]       x_dec_o,
  output logic [1:0]       y_dec_o
);
  localparam int SH_W = 2 + 4*CNT_W + 4;

  logic [SH_W-1:0] shadow_q, live;

  assign live = {mode_i, x_off_i, y_off_i, width_i, height_i, x_dec_i, y_dec_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            shadow_q <= '0;
    else if (frame_start_i) shadow_q <= live;
  end

  // the first beat of a frame already sees the new setup
  assign {mode_o, x_off_o, y_off_o, width_o, height_o, x_dec_o, y_dec_o} =
      frame_start_i ? live : shadow_q;
endmodule

// File: rtl/vid_roi_pos.sv
module vid_roi_pos
  import vid_roi_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fval_i,
  input  logic             act_i,
  input  logic             pix_stb_i,
  input  logic             line_end_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] x_off_i,
  input  logic [CNT_W-1:0] y_off_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] height_i,
  input  logic [1:0]       x_dec_i,
  input  logic [1:0]       y_dec_i,
  output logic             keep_o,
  output logic             bound_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] x_cnt_q, y_cnt_q, kl_cnt_q;
  logic [CNT_W-1:0] x_mask, y_mask, x_org, y_org;
  logic [EXT_W-1:0] x_rel, y_rel;
  logic             is_area, is_line, is_stream;
  logic             x_win, y_win, x_phase, y_phase;
  logic             line_kept, pix_kept, pseudo_last;

  assign is_area   = (mode_i == MODE_AREA);
  assign is_line   = (mode_i == MODE_LINE);
  assign is_stream = !is_area && !is_line;

  assign x_mask = CNT_W'((1 << x_dec_i) - 1);
  assign y_mask = CNT_W'((1 << y_dec_i) - 1);
  assign x_org  = is_stream ? '0 : x_off_i;
  assign y_org  = is_area   ? y_off_i : '0;

  assign x_rel = {1'b0, x_cnt_q} - {1'b0, x_org};
  assign y_rel = {1'b0, y_cnt_q} - {1'b0, y_org};

  assign x_win = is_stream ||
                 (!x_rel[CNT_W] && (x_rel[CNT_W-1:0] < width_i));
  assign y_win = !is_area ||
                 (!y_rel[CNT_W] && (y_rel[CNT_W-1:0] < height_i));

  assign x_phase = (x_rel[CNT_W-1:0] & x_mask) == '0;
  assign y_phase = (y_rel[CNT_W-1:0] & y_mask) == '0;

  assign line_kept = y_win && y_phase;
  assign pix_kept  = x_win && x_phase;
  assign keep_o    = pix_stb_i && line_kept && pix_kept;

  assign pseudo_last = is_line && (height_i != '0) && line_kept &&
                       ((kl_cnt_q + 1'b1) == height_i);
  assign bound_o = line_end_i && fval_i && pseudo_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        x_cnt_q <= '0;
    else if (!act_i)    x_cnt_q <= '0;
    else if (pix_stb_i) x_cnt_q <= x_cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_cnt_q  <= '0;
      kl_cnt_q <= '0;
    end else if (!fval_i) begin
      y_cnt_q  <= '0;
      kl_cnt_q <= '0;
    end else if (line_end_i) begin
      if (pseudo_last) begin
        y_cnt_q  <= '0;
        kl_cnt_q <= '0;
      end else begin
        y_cnt_q <= y_cnt_q + 1'b1;
        if (is_line && line_kept) kl_cnt_q <= kl_cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vid_roi_out.sv
module vid_roi_out #(
  parameter int PIX_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             keep_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             line_end_i,
  input  logic             frame_start_i,
  input  logic             bound_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eol_o
);
  logic             hold_vld_q, hold_sof_q, sof_pend_q, sof_now;
  logic [PIX_W-1:0] hold_pix_q;

  assign sof_now = sof_pend_q || frame_start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sof_pend_q <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_sof_q <= 1'b0;
      hold_pix_q <= '0;
    end else begin
      sof_pend_q <= keep_i ? bound_i : (sof_now || bound_i);
      if (keep_i) begin
        hold_vld_q <= 1'b1;
        hold_sof_q <= sof_now;
        hold_pix_q <= pix_i;
      end else if (line_end_i) begin
        hold_vld_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      sof_o   <= 1'b0;
      eol_o   <= 1'b0;
      pix_o   <= '0;
    end else begin
      valid_o <= hold_vld_q && (keep_i || line_end_i);
      sof_o   <= hold_vld_q && (keep_i || line_end_i) && hold_sof_q;
      eol_o   <= hold_vld_q && line_end_i;
      pix_o   <= hold_pix_q;
    end
  end
endmodule

// File: rtl/vid_roi_filter.sv
module vid_roi_filter #(
  parameter int PIX_W = 16,
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fval_i,
  input  logic             lval_i,
  input  logic             dval_i,
  input  logic [PIX_W-1:0] pix_i,
  input  logic [1:0]       mode_i,
  input  logic [CNT_W-1:0] x_off_i,
  input  logic [CNT_W-1:0] y_off_i,
  input  logic [CNT_W-1:0] width_i,
  input  logic [CNT_W-1:0] height_i,
  input  logic [1:0]       x_dec_i,
  input  logic [1:0]       y_dec_i,
  output logic [PIX_W-1:0] pix_o,
  output logic             valid_o,
  output logic             sof_o,
  output logic             eol_o
);
  logic             fval_q, act_q, act, frame_start, line_end, pix_stb;
  logic             keep, bound;
  logic [1:0]       c_mode, c_xdec, c_ydec;
  logic [CNT_W-1:0] c_xoff, c_yoff, c_width, c_height;

  assign act         = fval_i && lval_i;
  assign pix_stb     = act && dval_i;
  assign frame_start = fval_i && !fval_q;
  assign line_end    = act_q && !act;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fval_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      fval_q <= fval_i;
      act_q  <= act;
    end
  end

  vid_roi_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i, .rst_ni,
    .frame_start_i(frame_start),
    .mode_i, .x_off_i, .y_off_i, .width_i, .height_i, .x_dec_i, .y_dec_i,
    .mode_o(c_mode), .x_off_o(c_xoff), .y_off_o(c_yoff),
    .width_o(c_width), .height_o(c_height),
    .x_dec_o(c_xdec), .y_dec_o(c_ydec)
  );

  vid_roi_pos #(.CNT_W(CNT_W)) u_pos (
    .clk_i, .rst_ni, .fval_i,
    .act_i(act), .pix_stb_i(pix_stb), .line_end_i(line_end),
    .mode_i(c_mode), .x_off_i(c_xoff), .y_off_i(c_yoff),
    .width_i(c_width), .height_i(c_height),
    .x_dec_i(c_xdec), .y_dec_i(c_ydec),
    .keep_o(keep), .bound_o(bound)
  );

  vid_roi_out #(.PIX_W(PIX_W)) u_out (
    .clk_i, .rst_ni,
    .keep_i(keep), .pix_i, .line_end_i(line_end),
    .frame_start_i(frame_start), .bound_i(bound),
    .pix_o, .valid_o, .sof_o, .eol_o
  );
endmodule

// File: rtl/vid_roi_chk.sv
module vid_roi_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fval_i,
  input logic lval_i,
  input logic dval_i,
  input logic valid_o,
  input logic sof_o,
  input logic eol_o
);
  AST_SOF_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sof_o |-> valid_o); // R7

  AST_EOL_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> valid_o); // R8

  AST_EOL_AFTER_CLOSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |-> !$past(fval_i && lval_i)); // R8

  AST_EOL_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eol_o |=> !eol_o); // R8

  AST_MID_NEEDS_BEAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !eol_o) |-> $past(fval_i && lval_i && dval_i)); // R6
endmodule

bind vid_roi_filter vid_roi_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fval_i(fval_i), .lval_i(lval_i),
  .dval_i(dval_i), .valid_o(valid_o), .sof_o(sof_o), .eol_o(eol_o)
);

// File: tb/tb_vid_roi_filter.sv
module tb_vid_roi_filter;
  localparam int CLK_P = 10;
  localparam int PIX_W = 16;
  localparam int CNT_W = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fval = 1'b0, lval = 1'b0, dval = 1'b0;
  logic [PIX_W-1:0] pix = '0;
  logic [1:0] mode_r = '0, xd_r = '0, yd_r = '0;
  logic [CNT_W-1:0] xo_r = '0, yo_r = '0, w_r = '0, h_r = '0;
  logic [PIX_W-1:0] pix_o;
  logic valid_o, sof_o, eol_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [17:0] exp_q[$], act_q[$];
  int chg_at = -1;
  logic [CNT_W-1:0] alt_xo = '0;

  always #(CLK_P/2) clk = ~clk;

  vid_roi_filter #(.PIX_W(PIX_W), .CNT_W(CNT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .fval_i(fval), .lval_i(lval), .dval_i(dval),
    .pix_i(pix), .mode_i(mode_r), .x_off_i(xo_r), .y_off_i(yo_r),
    .width_i(w_r), .height_i(h_r), .x_dec_i(xd_r), .y_dec_i(yd_r),
    .pix_o(pix_o), .valid_o(valid_o), .sof_o(sof_o), .eol_o(eol_o)
  );

  always @(negedge clk) if (rst_n && valid_o) act_q.push_back({sof_o, eol_o, pix_o});

  task automatic check(bit ok, string req, logic [31:0] a, logic [31:0] e);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic set_cfg(int m, int xo, int yo, int w, int h, int xd, int yd);
    mode_r = 2'(m); xo_r = CNT_W'(xo); yo_r = CNT_W'(yo);
    w_r = CNT_W'(w); h_r = CNT_W'(h); xd_r = 2'(xd); yd_r = 2'(yd);
  endtask

  function automatic int line_len(int l, int len, bit vary);
    return vary ? len + (l % 3) * 2 : len;
  endfunction

  // expected output built from the requirements
  task automatic model_frame(int lines, int len, bit vary);
    int m = int'(mode_r), fx = 1 << xd_r, fy = 1 << yd_r;
    int xo = int'(xo_r), yo = int'(yo_r), w = int'(w_r), h = int'(h_r);
    bit sofp = 1;
    int y = 0, kl = 0;
    for (int l = 0; l < lines; l++) begin
      bit lk, have = 0;
      logic [17:0] last = '0;
      if (m == 0)      lk = (y >= yo) && (y < yo + h) && (((y - yo) % fy) == 0);
      else             lk = (y % fy) == 0;
      for (int x = 0; x < line_len(l, len, vary); x++) begin
        bit pk;
        if (m >= 2) pk = (x % fx) == 0;
        else        pk = (x >= xo) && (x < xo + w) && (((x - xo) % fx) == 0);
        if (lk && pk) begin
          if (have) exp_q.push_back(last);
          last = {sofp, 1'b0, l[7:0], x[7:0]};
          sofp = 0;
          have = 1;
        end
      end
      if (have) begin
        last[16] = 1'b1;
        exp_q.push_back(last);
      end
      if (m == 1 && lk) begin
        kl++;
        if (h != 0 && kl == h) begin
          kl = 0; y = 0; sofp = 1;
        end else y++;
      end else y++;
    end
  endtask

  task automatic drive_frame(int lines, int len, bit vary, int gap);
    int cyc = 0;
    @(negedge clk); fval = 1'b1;
    repeat (2) @(negedge clk);
    for (int l = 0; l < lines; l++) begin
      if (l == chg_at) xo_r = alt_xo;
      for (int x = 0; x < line_len(l, len, vary); x++) begin
        if (gap != 0 && (cyc % gap) == gap - 1) begin
          lval = 1'b1; dval = 1'b0; pix = 16'hdead;
          @(negedge clk);
          cyc++;
        end
        lval = 1'b1; dval = 1'b1; pix = {l[7:0], x[7:0]};
        @(negedge clk);
        cyc++;
      end
      lval = 1'b0; dval = 1'b0; pix = 16'hbeef;
      repeat (3) @(negedge clk);
    end
    fval = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(string req);
    check(act_q.size() == exp_q.size(), {req, " count"}, act_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size(); i++) begin
      logic [17:0] a = (i < act_q.size()) ? act_q[i] : 18'h3ffff;
      check(a == exp_q[i], req, a, exp_q[i]);
    end
    exp_q.delete();
    act_q.delete();
  endtask

  task automatic t_reset;
    check(valid_o == 1'b0 && sof_o == 1'b0 && eol_o == 1'b0, "R10 reset outputs",
          {valid_o, sof_o, eol_o}, 0);
  endtask

  task automatic t_area_plain;
    set_cfg(0, 2, 1, 5, 3, 0, 0);
    model_frame(6, 10, 0);
    drive_frame(6, 10, 0, 0);
    compare("R1 R7 R8 area window");
  endtask

  task automatic t_area_decim;
    set_cfg(0, 1, 0, 9, 6, 2, 1);
    model_frame(8, 12, 0);
    drive_frame(8, 12, 0, 3);
    compare("R5 R6 area x4 y2 with gaps");
  endtask

  task automatic t_line_pseudo;
    set_cfg(1, 3, 2, 4, 2, 0, 0);
    model_frame(5, 9, 0);
    drive_frame(5, 9, 0, 0);
    compare("R2 R3 line pseudo-frames");
  endtask

  task automatic t_line_nogroup;
    set_cfg(1, 0, 0, 3, 0, 1, 1);
    model_frame(6, 6, 0);
    drive_frame(6, 6, 0, 0);
    compare("R3 R5 line height0 decimated");
  endtask

  task automatic t_stream;
    set_cfg(2, 3, 2, 1, 1, 1, 0);
    model_frame(4, 5, 1);
    drive_frame(4, 5, 1, 4);
    compare("R4 R8 stream varying lines");
  endtask

  task automatic t_x8;
    set_cfg(3, 0, 0, 0, 0, 3, 2);
    model_frame(9, 20, 0);
    drive_frame(9, 20, 0, 0);
    compare("R5 stream x8 y4");
  endtask

  task automatic t_midframe;
    set_cfg(0, 1, 0, 6, 4, 0, 0);
    model_frame(4, 8, 0);
    alt_xo = CNT_W'(4);
    chg_at = 2;
    drive_frame(4, 8, 0, 0);
    chg_at = -1;
    compare("R9 mid-frame change ignored");
    model_frame(4, 8, 0);
    drive_frame(4, 8, 0, 0);
    compare("R9 change applies next frame");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_area_plain();
    t_area_decim();
    t_line_pseudo();
    t_line_nogroup();
    t_stream();
    t_x8();
    t_midframe();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule